// File: doc/BRIEF.md
# Stuck-at Fault Injection Comparator

This block evaluates a small three-input combinational function, Z = x1·x2 + x2·x3, built as two AND gates feeding an OR gate. It holds two copies of that netlist. One copy is always fault-free. The other can have a single internal net forced to a constant 0 or 1. The caller supplies an input vector and a fault descriptor, which gives the net index, the stuck value and an injection enable, together with a one-cycle strobe. One clock later the block returns both responses. It also returns a flag that is set when the responses differ, and a separate flag that is set when the vector drives the chosen net to the opposite of its stuck value.

The block is used to confirm vectors produced by path sensitization. A vector that raises the activation flag but not the difference flag excites the fault without propagating it to the output. A vector that raises both is a test for that fault.

Control is a two-state machine. WAIT means that no fresh result is presented. SHOW means that the result of the previous cycle's strobe is on the outputs. The transitions are:
- WAIT→SHOW on a strobe.
- SHOW→SHOW on a strobe.
- SHOW→WAIT when no strobe arrives.
- WAIT→WAIT when no strobe arrives.

Reset enters WAIT.

Top module: `sa_miter`

## Requirements
- R1: One cycle after a strobe, `good_z` equals x1&x2 | x2&x3 for the strobed vector, where x1 = `vec[0]`, x2 = `vec[1]` and x3 = `vec[2]`.
- R2: One cycle after a strobe with injection enabled, `faulty_z` equals the netlist output with the selected net held at `stuck_val`. The site codes are: 0 = x1, 1 = the x2 branch into the first AND, 2 = the x2 branch into the second AND, 3 = x3, 4 = the output of the first AND, 5 = the output of the second AND, 6 = Z. Code 7 selects no net.
- R3: `detected` equals `good_z` XOR `faulty_z` for the same strobe.
- R4: `activated` is 1 exactly when injection is enabled, the site code is 0 to 6, and the fault-free value at that net differs from `stuck_val`.
- R5: With `fault_en` = 0, `faulty_z` equals `good_z`, and both `detected` and `activated` are 0, for every site and stuck value.
- R6: `out_valid` is 1 in the cycle after a strobe and 0 in the cycle after a cycle without one. All result outputs hold their values while no strobe arrives.
- R7: After reset, `out_valid`, `good_z`, `faulty_z`, `detected` and `activated` are all 0.
- R8: A stuck fault that is not activated never raises `detected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: sample the vector and the fault descriptor |
| vec | input | 3 | Input vector: bit 0 is x1, bit 1 is x2, bit 2 is x3 |
| fault_en | input | 1 | Injection enable |
| fault_site | input | 3 | Index of the faulted net (7 selects no net) |
| stuck_val | input | 1 | Value the faulted net is held at |
| out_valid | output | 1 | A result from the previous cycle's strobe is presented |
| good_z | output | 1 | Fault-free response |
| faulty_z | output | 1 | Response of the faulted copy |
| detected | output | 1 | The two responses differ |
| activated | output | 1 | The fault site is excited by the vector |

## Verification
Every result is registered once, so all five outputs are due at the first rising edge after the strobe is sampled. The bench drives inputs on falling edges. It reads outputs on the next falling edge, half a period after the edge that loads them. It then reads them again one full cycle later with the strobe low, to confirm that they hold and that `out_valid` has dropped. Strobes run back to back during the exhaustive sweep, so every sample shows exactly the previous cycle's inputs.

// File: rtl/sa_miter_pkg.sv
package sa_miter_pkg;
    localparam int VEC_W    = 3;
    localparam int SITE_W   = 3;
    localparam int NET_CNT  = 7;
    localparam logic [SITE_W-1:0] SITE_NONE = SITE_W'(NET_CNT);

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_SHOW = 1'b1
    } ctrl_state_t;

    typedef struct packed {
        logic good;
        logic faulty;
        logic act;
    } result_t;
endpackage

// File: rtl/sa_netlist.sv
module sa_netlist
    import sa_miter_pkg::*;
(
    input  logic [VEC_W-1:0]  vec,
    input  logic              inject,
    input  logic [SITE_W-1:0] site,
    input  logic              stuck,
    output logic              z,
    output logic              tap
);
    localparam int TAP_N = 1 << SITE_W;

    logic [TAP_N-1:0] net;

    function automatic logic pin(input logic raw, input int idx,
                                 input logic en, input logic [SITE_W-1:0] s,
                                 input logic v);
        return (en && s == SITE_W'(idx)) ? v : raw;
    endfunction

    always_comb begin
        net    = '0;
        net[0] = pin(vec[0],          0, inject, site, stuck);
        net[1] = pin(vec[1],          1, inject, site, stuck);
        net[2] = pin(vec[1],          2, inject, site, stuck);
        net[3] = pin(vec[2],          3, inject, site, stuck);
        net[4] = pin(net[0] & net[1], 4, inject, site, stuck);
        net[5] = pin(net[2] & net[3], 5, inject, site, stuck);
        net[6] = pin(net[4] | net[5], 6, inject, site, stuck);
        z      = net[NET_CNT-1];
        tap    = (site == SITE_NONE) ? 1'b0 : net[site];
    end
endmodule

// File: rtl/sa_miter.sv
module sa_miter
    import sa_miter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  vec,
    input  logic              fault_en,
    input  logic [SITE_W-1:0] fault_site,
    input  logic              stuck_val,
    output logic              out_valid,
    output logic              good_z,
    output logic              faulty_z,
    output logic              detected,
    output logic              activated
);
    ctrl_state_t state_q, state_d;
    result_t     res_q, res_d;
    logic        g_z, f_z, g_tap, f_tap_unused;

    sa_netlist u_good (
        .vec(vec), .inject(1'b0), .site(fault_site), .stuck(stuck_val),
        .z(g_z), .tap(g_tap)
    );

    sa_netlist u_faulty (
        .vec(vec), .inject(fault_en), .site(fault_site), .stuck(stuck_val),
        .z(f_z), .tap(f_tap_unused)
    );

    always_comb begin
        res_d.good   = g_z;
        res_d.faulty = f_z;
        res_d.act    = fault_en && (fault_site != SITE_NONE) && (g_tap != stuck_val);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (in_valid)  state_d = ST_SHOW;
            ST_SHOW: if (!in_valid) state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (in_valid) res_q <= res_d;
    end

    always_comb begin
        out_valid = (state_q == ST_SHOW);
        good_z    = res_q.good;
        faulty_z  = res_q.faulty;
        detected  = res_q.good ^ res_q.faulty;
        activated = res_q.act;
    end

    AST_GOOD_FUNC: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> good_z == ($past(vec[0] & vec[1]) | $past(vec[1] & vec[2]))); // R1
    AST_NO_INJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fault_en) |=> (!detected && !activated)); // R5
    AST_DETECT_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
        detected |-> activated); // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R6
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(good_z) && $stable(faulty_z) && $stable(activated))); // R6
endmodule

// File: tb/sa_miter_tb.sv
module sa_miter_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [2:0] vec = '0;
    logic fault_en = 1'b0;
    logic [2:0] fault_site = '0;
    logic stuck_val = 1'b0;
    logic out_valid, good_z, faulty_z, detected, activated;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sa_miter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vec(vec),
        .fault_en(fault_en), .fault_site(fault_site), .stuck_val(stuck_val),
        .out_valid(out_valid), .good_z(good_z), .faulty_z(faulty_z),
        .detected(detected), .activated(activated)
    );

    // Reference model: nets listed explicitly, fault forced on one of them
    function automatic logic [7:0] ref_nets(input logic [2:0] v, input logic en,
                                            input logic [2:0] s, input logic sv);
        logic [7:0] n;
        logic a, b, c, d;
        a = (en && s == 3'd0) ? sv : v[0];
        b = (en && s == 3'd1) ? sv : v[1];
        c = (en && s == 3'd2) ? sv : v[1];
        d = (en && s == 3'd3) ? sv : v[2];
        n = '0;
        n[0] = a; n[1] = b; n[2] = c; n[3] = d;
        n[4] = (en && s == 3'd4) ? sv : (a & b);
        n[5] = (en && s == 3'd5) ? sv : (c & d);
        n[6] = (en && s == 3'd6) ? sv : (n[4] | n[5]);
        return n;
    endfunction

    function automatic logic exp_act(input logic [2:0] v, input logic en,
                                     input logic [2:0] s, input logic sv);
        logic [7:0] g;
        g = ref_nets(v, 1'b0, s, sv);
        return en && (s != 3'd7) && (g[s] != sv);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (vec=%b en=%b site=%0d sv=%b)",
                     req, act, exp, vec, fault_en, fault_site, stuck_val);
        end
    endtask

    logic [2:0] p_vec, p_site;
    logic p_en, p_sv;

    task automatic check_last();
        logic [7:0] g, f;
        g = ref_nets(p_vec, 1'b0, p_site, p_sv);
        f = ref_nets(p_vec, p_en, p_site, p_sv);
        chk("R6 out_valid", out_valid, 1'b1);
        chk("R1 good_z", good_z, g[6]);
        chk(p_en ? "R2 faulty_z" : "R5 faulty_z", faulty_z, f[6]);
        chk("R3 detected", detected, g[6] ^ f[6]);
        chk("R4 activated", activated, exp_act(p_vec, p_en, p_site, p_sv));
        if (!exp_act(p_vec, p_en, p_site, p_sv)) chk("R8 no detect w/o act", detected, 1'b0);
        if (!p_en) begin
            chk("R5 detected off", detected, 1'b0);
            chk("R5 activated off", activated, 1'b0);
        end
    endtask

    task automatic strobe(input logic [2:0] v, input logic en,
                          input logic [2:0] s, input logic sv);
        vec = v; fault_en = en; fault_site = s; stuck_val = sv; in_valid = 1'b1;
        p_vec = v; p_en = en; p_site = s; p_sv = sv;
        @(negedge clk);
        check_last();
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic hg, hf, ha;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 out_valid", out_valid, 1'b0);
        chk("R7 good_z", good_z, 1'b0);
        chk("R7 faulty_z", faulty_z, 1'b0);
        chk("R7 detected", detected, 1'b0);
        chk("R7 activated", activated, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners: x2 branch into AND1 stuck at 1 gives x1 + x2x3
        strobe(3'b001, 1'b1, 3'd1, 1'b1); // x1=1,x2=0: good 0, faulty 1
        strobe(3'b111, 1'b1, 3'd4, 1'b1); // AND1 out s-a-1, not activated
        strobe(3'b000, 1'b1, 3'd7, 1'b1); // R2 site 7 selects nothing

        // Exhaustive sweep, back-to-back strobes
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 8; s++)
                for (int b = 0; b < 2; b++)
                    for (int v = 0; v < 8; v++)
                        strobe(3'(v), 1'(e), 3'(s), 1'(b));

        // R6: no strobe, inputs change, outputs hold
        hg = good_z; hf = faulty_z; ha = activated;
        in_valid = 1'b0; vec = ~vec; fault_site = 3'd0; stuck_val = ~stuck_val;
        @(negedge clk);
        chk("R6 out_valid low", out_valid, 1'b0);
        chk("R6 hold good_z", good_z, hg);
        chk("R6 hold faulty_z", faulty_z, hf);
        chk("R6 hold activated", activated, ha);

        // Random mix with gaps
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(3, 0) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk("R6 gap out_valid", out_valid, 1'b0);
            end else begin
                strobe(3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)),
                       3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)));
            end
        end
        in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule